// File: doc/BRIEF.md
# Accumulator ALU with Flag Unit

This block is the arithmetic and logic stage of a small accumulator machine. Each cycle it takes an operation code, the accumulator value and one 8-bit operand. It produces an 8-bit result, a write strobe for the accumulator and the next value of the five status flags. The result, the strobe and the next flags are combinational. The block holds the flags in its own register, and that register loads the next flags on every clock edge where `op_en` is high.

Each class of operation follows its own flag rule. Arithmetic operations recompute every flag. Logic operations force the half-carry and the carry to fixed values. Increment and decrement keep the carry. Rotates touch only the carry. Compare sets the flags and writes nothing to the accumulator. Decimal adjust reads the half-carry and the carry to decide which nibbles to correct. The surrounding datapath handles instruction fetch, operand selection and the register file. For increment and decrement it writes `res_out` back to wherever the operand came from.

Top module: `alu_flag_unit`

## Requirements
- R1: During reset and on the first cycle after it, `flags_q` equals the parameter `RST_FLAGS` (default all zero). On a clock edge with `op_en` low, `flags_q` keeps its value. The flag bits are `flags_q[4]`=S (sign, result bit 7), `[3]`=Z (zero), `[2]`=AC (half carry), `[1]`=P (1 when the result has an even number of ones) and `[0]`=CY.
- R2: Codes 0 (add) and 1 (add with carry) return acc+opnd, and code 1 adds CY as well. All five flags come from this sum. AC is the carry out of bit 3 and CY is the carry out of bit 7.
- R3: Codes 2 (subtract) and 3 (subtract with borrow) return acc-opnd, and code 3 subtracts CY as well. CY is 1 when a borrow occurs. AC is the inverse of the borrow out of bit 3. S, Z and P come from the result.
- R4: Code 4 (AND) returns acc&opnd, sets AC to 1, clears CY, and derives S, Z and P from the result.
- R5: Codes 5 (XOR) and 6 (OR) return acc^opnd and acc|opnd. Both clear AC and CY and derive S, Z and P from the result.
- R6: Code 7 (compare) sets the flags exactly as code 2 would, so CY=1 when acc<opnd and Z=1 when they are equal. `acc_we` stays low.
- R7: Codes 8 (increment) and 9 (decrement) return opnd+1 and opnd-1 on `res_out` with `acc_we` low. They update S, Z, P and AC, and never change CY.
- R8: Code 10 rotates left and code 11 rotates right, each copying the bit that leaves into the vacated end and into CY. Codes 12 and 13 rotate left and right through CY. Only CY changes among the flags.
- R9: Code 14 returns ~acc and changes no flag. Code 15 sets CY and code 16 inverts CY. Codes 15 and 16 leave the other flags unchanged and keep `acc_we` low.
- R10: Code 17 (decimal adjust) first adds 6 when the low nibble is above 9 or AC=1. It then adds 60h when the high nibble of that intermediate value is above 9 or CY=1. CY becomes 1 on any carry out of bit 7 and otherwise keeps its prior value. AC is the carry out of bit 3 in the first step. S, Z and P come from the result.
- R11: Codes 18 to 31 have no effect: `acc_we` stays low and `flags_nxt` equals `flags_q`.
- R12: `acc_we` is high only when `op_en` is high and the code writes the accumulator (codes 0-6, 10-14 and 17). On a clock edge with `op_en` high, `flags_q` takes the `flags_nxt` value shown before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_en | input | 1 | Execute strobe; commits flags and enables the accumulator write |
| op_code | input | 5 | Operation select |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Second operand; also the target of increment and decrement |
| res_out | output | 8 | Operation result |
| acc_we | output | 1 | Accumulator write enable |
| flags_nxt | output | 5 | Flags the current operation would commit |
| flags_q | output | 5 | Registered flags {S,Z,AC,P,CY} |

## Verification
The bench builds the block with `RST_FLAGS` at its default of all zero. The first carry-dependent operations after reset therefore see a known clear CY, and the directed examples start from a predictable state. The full 5-bit code space is driven, so the 14 unused codes and the `op_en`-low hold cycles get exercised alongside the decimal-adjust corner where the low-nibble fix carries past bit 7.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    localparam int DW  = 8;
    localparam int NW  = DW / 2;
    localparam int OPW = 5;
    localparam int FLW = 5;

    typedef enum logic [OPW-1:0] {
        OP_ADD = 5'd0,
        OP_ADC = 5'd1,
        OP_SUB = 5'd2,
        OP_SBB = 5'd3,
        OP_AND = 5'd4,
        OP_XOR = 5'd5,
        OP_OR  = 5'd6,
        OP_CMP = 5'd7,
        OP_INR = 5'd8,
        OP_DCR = 5'd9,
        OP_RLC = 5'd10,
        OP_RRC = 5'd11,
        OP_RAL = 5'd12,
        OP_RAR = 5'd13,
        OP_CMA = 5'd14,
        OP_STC = 5'd15,
        OP_CMC = 5'd16,
        OP_DAA = 5'd17
    } op_e;

    typedef struct packed {
        logic s;
        logic z;
        logic ac;
        logic p;
        logic cy;
    } flags_t;

    function automatic flags_t mk_flags(logic [DW-1:0] v, logic ac, logic cy);
        flags_t f;
        f.s  = v[DW-1];
        f.z  = (v == '0);
        f.ac = ac;
        f.p  = ~^v;
        f.cy = cy;
        return f;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_flag_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cy_in,
    input  logic          sub,
    input  logic          use_cin,
    output logic [DW-1:0] res,
    output logic          ac,
    output logic          cy
);
    logic [DW-1:0] bx;
    logic          cin;
    logic [DW:0]   full;
    logic [NW:0]   lo;

    always_comb begin
        bx   = sub ? ~b : b;
        cin  = sub ? ~(use_cin & cy_in) : (use_cin & cy_in);
        full = {1'b0, a} + {1'b0, bx} + {{DW{1'b0}}, cin};
        lo   = {1'b0, a[NW-1:0]} + {1'b0, bx[NW-1:0]} + {{NW{1'b0}}, cin};
        res  = full[DW-1:0];
        ac   = lo[NW];
        cy   = sub ? ~full[DW] : full[DW];
    end
endmodule

// File: rtl/alu_incdec.sv
module alu_incdec
    import alu_flag_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic          dec,
    output logic [DW-1:0] res,
    output logic          ac
);
    logic [NW:0] lo;

    always_comb begin
        res = dec ? (a + {DW{1'b1}}) : (a + {{(DW-1){1'b0}}, 1'b1});
        lo  = dec ? ({1'b0, a[NW-1:0]} + {1'b0, {NW{1'b1}}})
                  : ({1'b0, a[NW-1:0]} + {{NW{1'b0}}, 1'b1});
        ac  = lo[NW];
    end
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
    import alu_flag_pkg::*;
(
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    input  logic           cy_in,
    output logic [DW-1:0]  res,
    output logic           ac,
    output logic           cy
);
    always_comb begin
        res = a;
        ac  = 1'b0;
        cy  = cy_in;
        case (op)
            OP_AND: begin res = a & b; ac = 1'b1; cy = 1'b0; end
            OP_XOR: begin res = a ^ b; cy = 1'b0; end
            OP_OR:  begin res = a | b; cy = 1'b0; end
            OP_RLC: begin res = {a[DW-2:0], a[DW-1]}; cy = a[DW-1]; end
            OP_RRC: begin res = {a[0], a[DW-1:1]};    cy = a[0];    end
            OP_RAL: begin res = {a[DW-2:0], cy_in};   cy = a[DW-1]; end
            OP_RAR: begin res = {cy_in, a[DW-1:1]};   cy = a[0];    end
            OP_CMA: res = ~a;
            OP_STC: cy = 1'b1;
            OP_CMC: cy = ~cy_in;
            default: ;
        endcase
    end
endmodule

// File: rtl/alu_decadj.sv
module alu_decadj
    import alu_flag_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic          ac_in,
    input  logic          cy_in,
    output logic [DW-1:0] res,
    output logic          ac,
    output logic          cy
);
    localparam logic [DW:0] LO_ADJ = (DW+1)'(6);
    localparam logic [DW:0] HI_ADJ = (DW+1)'(6 << NW);

    logic          lo_fix, hi_fix;
    logic [NW:0]   lo;
    logic [DW:0]   t, u;

    always_comb begin
        lo_fix = (a[NW-1:0] > NW'(9)) || ac_in;
        lo     = {1'b0, a[NW-1:0]} + (lo_fix ? (NW+1)'(6) : '0);
        t      = {1'b0, a} + (lo_fix ? LO_ADJ : '0);
        hi_fix = (t[DW-1:NW] > NW'(9)) || cy_in;
        u      = {1'b0, t[DW-1:0]} + (hi_fix ? HI_ADJ : '0);
        res    = u[DW-1:0];
        ac     = lo[NW];
        cy     = cy_in | t[DW] | u[DW];
    end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import alu_flag_pkg::*;
#(
    parameter logic [FLW-1:0] RST_FLAGS = '0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           op_en,
    input  logic [OPW-1:0] op_code,
    input  logic [DW-1:0]  acc_in,
    input  logic [DW-1:0]  opnd_in,
    output logic [DW-1:0]  res_out,
    output logic           acc_we,
    output logic [FLW-1:0] flags_nxt,
    output logic [FLW-1:0] flags_q
);
    flags_t        fq, fn;
    logic          wr;
    logic [DW-1:0] res;

    logic          as_sub, as_cin;
    logic [DW-1:0] as_res;
    logic          as_ac, as_cy;
    logic [DW-1:0] id_res;
    logic          id_ac;
    logic [DW-1:0] bo_res;
    logic          bo_ac, bo_cy;
    logic [DW-1:0] da_res;
    logic          da_ac, da_cy;

    assign as_sub = (op_code == OP_SUB) || (op_code == OP_SBB) || (op_code == OP_CMP);
    assign as_cin = (op_code == OP_ADC) || (op_code == OP_SBB);

    alu_addsub u_addsub (
        .a(acc_in), .b(opnd_in), .cy_in(fq.cy), .sub(as_sub), .use_cin(as_cin),
        .res(as_res), .ac(as_ac), .cy(as_cy)
    );

    alu_incdec u_incdec (
        .a(opnd_in), .dec(op_code == OP_DCR), .res(id_res), .ac(id_ac)
    );

    alu_bitops u_bitops (
        .op(op_code), .a(acc_in), .b(opnd_in), .cy_in(fq.cy),
        .res(bo_res), .ac(bo_ac), .cy(bo_cy)
    );

    alu_decadj u_decadj (
        .a(acc_in), .ac_in(fq.ac), .cy_in(fq.cy),
        .res(da_res), .ac(da_ac), .cy(da_cy)
    );

    always_comb begin
        res = acc_in;
        wr  = 1'b0;
        fn  = fq;
        case (op_code)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
                res = as_res;
                wr  = 1'b1;
                fn  = mk_flags(as_res, as_ac, as_cy);
            end
            OP_CMP: begin
                res = as_res;
                fn  = mk_flags(as_res, as_ac, as_cy);
            end
            OP_AND, OP_XOR, OP_OR: begin
                res = bo_res;
                wr  = 1'b1;
                fn  = mk_flags(bo_res, bo_ac, bo_cy);
            end
            OP_INR, OP_DCR: begin
                res = id_res;
                fn  = mk_flags(id_res, id_ac, fq.cy);
            end
            OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
                res   = bo_res;
                wr    = 1'b1;
                fn.cy = bo_cy;
            end
            OP_CMA: begin
                res = bo_res;
                wr  = 1'b1;
            end
            OP_STC, OP_CMC: fn.cy = bo_cy;
            OP_DAA: begin
                res = da_res;
                wr  = 1'b1;
                fn  = mk_flags(da_res, da_ac, da_cy);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        fq <= flags_t'(RST_FLAGS);
        else if (op_en) fq <= fn;
    end

    assign res_out   = res;
    assign acc_we    = op_en & wr;
    assign flags_nxt = fn;
    assign flags_q   = fq;
endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk
    import alu_flag_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           op_en,
    input logic [OPW-1:0] op_code,
    input logic           acc_we,
    input logic [FLW-1:0] flags_nxt,
    input logic [FLW-1:0] flags_q
);
    // R12
    flag_load_chk: assert property (@(posedge clk) disable iff (rst)
        op_en |=> (flags_q == $past(flags_nxt)));

    // R1
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !op_en |=> $stable(flags_q));

    // R6
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_CMP) |-> !acc_we);

    // R4
    and_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_AND) |-> (flags_nxt[2] && !flags_nxt[0]));

    // R7
    incdec_carry_chk: assert property (@(posedge clk) disable iff (rst)
        ((op_code == OP_INR) || (op_code == OP_DCR)) |-> (flags_nxt[0] == flags_q[0]));

    // R8
    rotate_flags_chk: assert property (@(posedge clk) disable iff (rst)
        ((op_code >= OP_RLC) && (op_code <= OP_RAR)) |-> (flags_nxt[4:1] == flags_q[4:1]));

    // R9
    cma_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_CMA) |-> (flags_nxt == flags_q));

    // R11
    unused_code_chk: assert property (@(posedge clk) disable iff (rst)
        (op_code > OP_DAA) |-> (!acc_we && (flags_nxt == flags_q)));

    // R12
    we_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !op_en |-> !acc_we);
endmodule

bind alu_flag_unit alu_flag_unit_chk u_chk (
    .clk(clk), .rst(rst), .op_en(op_en), .op_code(op_code),
    .acc_we(acc_we), .flags_nxt(flags_nxt), .flags_q(flags_q)
);

// File: tb/alu_flag_unit_test.sv
module alu_flag_unit_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_en = 1'b0;
    logic [4:0] op_code = '0;
    logic [7:0] acc_in = '0;
    logic [7:0] opnd_in = '0;
    logic [7:0] res_out;
    logic       acc_we;
    logic [4:0] flags_nxt;
    logic [4:0] flags_q;

    int         checks = 0;
    int         fails = 0;
    bit         done = 0;
    logic [4:0] mflags = '0;

    alu_flag_unit uut (
        .clk(clk), .rst(rst), .op_en(op_en), .op_code(op_code),
        .acc_in(acc_in), .opnd_in(opnd_in), .res_out(res_out),
        .acc_we(acc_we), .flags_nxt(flags_nxt), .flags_q(flags_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic string req_of(int op);
        if (op <= 1)  return "R2";
        if (op <= 3)  return "R3";
        if (op == 4)  return "R4";
        if (op <= 6)  return "R5";
        if (op == 7)  return "R6";
        if (op <= 9)  return "R7";
        if (op <= 13) return "R8";
        if (op <= 16) return "R9";
        if (op == 17) return "R10";
        return "R11";
    endfunction

    // returns {write, result[7:0], S, Z, AC, P, CY}
    function automatic logic [13:0] model(int op, int a, int b, logic [4:0] f);
        int r, s, z, ac, p, cy, wr, c, d, t, u, ones, adj, c1;
        bit upd;
        logic [13:0] o;
        s = f[4]; z = f[3]; ac = f[2]; p = f[1]; cy = f[0];
        r = a; wr = 0; upd = 0;
        case (op)
            0, 1: begin
                c = (op == 1) ? cy : 0;
                r = a + b + c;
                ac = (((a % 16) + (b % 16) + c) > 15) ? 1 : 0;
                cy = (r > 255) ? 1 : 0;
                r = r % 256; wr = 1; upd = 1;
            end
            2, 3, 7: begin
                c = (op == 3) ? cy : 0;
                d = a - b - c;
                cy = (d < 0) ? 1 : 0;
                ac = (((a % 16) - (b % 16) - c) >= 0) ? 1 : 0;
                r = (d + 256) % 256; wr = (op != 7) ? 1 : 0; upd = 1;
            end
            4: begin r = a & b; ac = 1; cy = 0; wr = 1; upd = 1; end
            5: begin r = a ^ b; ac = 0; cy = 0; wr = 1; upd = 1; end
            6: begin r = a | b; ac = 0; cy = 0; wr = 1; upd = 1; end
            8: begin r = (b + 1) % 256;   ac = ((b % 16) == 15) ? 1 : 0; upd = 1; end
            9: begin r = (b + 255) % 256; ac = ((b % 16) != 0) ? 1 : 0;  upd = 1; end
            10: begin r = ((a * 2) % 256) + (a / 128); cy = a / 128; wr = 1; end
            11: begin r = (a / 2) + ((a % 2) * 128);   cy = a % 2;   wr = 1; end
            12: begin r = ((a * 2) % 256) + cy; cy = a / 128; wr = 1; end
            13: begin r = (a / 2) + cy * 128;   cy = a % 2;   wr = 1; end
            14: begin r = 255 - a; wr = 1; end
            15: cy = 1;
            16: cy = 1 - cy;
            17: begin
                adj = (((a % 16) > 9) || (ac != 0)) ? 6 : 0;
                ac = (((a % 16) + adj) > 15) ? 1 : 0;
                t = a + adj;
                c1 = (t > 255) ? 1 : 0;
                t = t % 256;
                u = t + ((((t / 16) > 9) || (cy != 0)) ? 96 : 0);
                if (c1 != 0 || u > 255) cy = 1;
                r = u % 256; wr = 1; upd = 1;
            end
            default: ;
        endcase
        if (upd) begin
            ones = 0;
            for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
            s = r / 128;
            z = (r == 0) ? 1 : 0;
            p = ((ones % 2) == 0) ? 1 : 0;
        end
        o[13]  = (wr != 0);
        o[12:5] = r[7:0];
        o[4] = s[0]; o[3] = z[0]; o[2] = ac[0]; o[1] = p[0]; o[0] = cy[0];
        return o;
    endfunction

    task automatic check(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(int op, int a, int b, bit en);
        logic [13:0] e;
        string tag;
        tag = req_of(op);
        @(negedge clk);
        op_code = op[4:0];
        acc_in  = a[7:0];
        opnd_in = b[7:0];
        op_en   = en;
        #1;
        e = model(op, a, b, mflags);
        check("R12", int'(acc_we), int'(e[13] & en), {tag, " acc_we"});
        if (e[13] || op == 7 || op == 8 || op == 9)
            check(tag, int'(res_out), int'(e[12:5]), "res_out");
        check(tag, int'(flags_nxt), int'(e[4:0]), "flags_nxt");
        @(posedge clk);
        #1;
        if (en) mflags = e[4:0];
        check(en ? "R12" : "R1", int'(flags_q), int'(mflags), "flags_q");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", int'(flags_q), 0, "flags_q in reset");
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1", int'(flags_q), 0, "flags_q after reset");

        // R2 add with carry: 26h + 57h + 1 = 7Eh
        step(15, 0, 0, 1);
        step(1, 'h26, 'h57, 1);
        // R3 subtract with borrow: 37h - 3Fh - 1 = F7h
        step(15, 0, 0, 1);
        step(3, 'h37, 'h3F, 1);
        step(2, 'h37, 'h40, 1);
        step(0, 'h47, 'h51, 1);
        step(0, 'h98, 'h80, 1);
        // R4 AND gives zero with AC forced
        step(4, 'h54, 'h82, 1);
        // R5 OR and XOR
        step(6, 'h03, 'h81, 1);
        step(5, 'hFF, 'hFF, 1);
        // R6 compare below, equal, above
        step(7, 'h57, 'h62, 1);
        step(7, 'hC2, 'hC2, 1);
        step(7, 'hC2, 'h98, 1);
        // R7 increment wrap keeps CY
        step(15, 0, 0, 1);
        step(8, 0, 'hFF, 1);
        step(9, 0, 'h00, 1);
        step(9, 0, 'hA0, 1);
        // R8 rotates
        step(16, 0, 0, 1);
        step(12, 'hA7, 0, 1);
        step(13, 'hA7, 0, 1);
        step(10, 'hA7, 0, 1);
        step(11, 'hA7, 0, 1);
        // R9 complement and carry ops
        step(14, 'h89, 0, 1);
        step(16, 0, 0, 1);
        step(15, 0, 0, 1);
        // R10 decimal adjust 85 + 68 -> 53 with carry
        step(0, 'h85, 'h68, 1);
        step(17, 'hED, 0, 1);
        step(0, 'h09, 'h01, 1);
        step(17, 'hFA, 0, 1);
        // R11 unused codes
        step(18, 'h12, 'h34, 1);
        step(31, 'hFF, 'h01, 1);
        // R1 hold with op_en low
        step(0, 'hFF, 'h01, 0);
        step(4, 'h00, 'h00, 0);

        for (int n = 0; n < 800; n++) begin
            step(int'($urandom_range(0, 31)), int'($urandom_range(0, 255)),
                 int'($urandom_range(0, 255)), ($urandom_range(0, 7) != 0));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule